// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serialises bytes onto an asynchronous serial line. A single holding register sits in front of the frame shifter, so the producer can queue the next byte while the current frame is still going out. The shifter sends one start bit (0), then 8 or 9 data bits starting with the least significant, then one stop bit (1). Each bit lasts one interval of the external one-cycle baud tick.

A queued byte is loaded at the tick that ends the stop bit, so consecutive frames follow each other with no idle bit between them. Two flags report readiness. `hold_empty` shows that the holding register can take another byte. `tx_done` shows that the line has gone quiet after the last stop bit, and it stays set until it is cleared.

In 9-bit mode the extra data bit comes from a separate input that is captured along with the byte. The transmitter only runs while `tx_en` is high.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_done` is 0.
- R2: When `wr_stb` is sampled, `hold_empty` is 0 in the next cycle. If the shifter is idle and `tx_en` is high, the byte moves to the shifter on the following edge and `hold_empty` returns to 1.
- R3: In 8-bit mode (`mode9`=0) a frame is 10 bits long: a start bit of 0, `wr_data` bits 0 to 7 in that order, and a stop bit of 1.
- R4: `txd` changes only on edges where `baud_tick` is high. The start bit appears on the first tick after the byte moves to the shifter, and every bit then holds for exactly one tick interval.
- R5: In 9-bit mode (`mode9`=1, sampled when the byte moves into the shifter) a frame is 11 bits long. The `wr_bit9` value captured with the byte goes out after data bit 7 and before the stop bit.
- R6: If a byte is pending when the stop bit ends, it is loaded at that tick and its start bit begins there. The start ticks of the two frames are exactly one frame length apart, with no idle bit between them.
- R7: `tx_done` rises on the tick edge that ends a stop bit with nothing pending, and only then. It stays 0 across gapless frames.
- R8: `tx_done` is cleared by `tc_clr` or by `wr_stb`. A clear has priority over a set in the same cycle.
- R9: A write while a byte is already pending replaces that byte. Only the last byte written is transmitted.
- R10: While `tx_en` is 0, `txd` is held at 1 and a pending byte stays in the holding register (`hold_empty`=0). It is sent once `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| mode9 | input | 1 | 1 selects 9 data bits per frame |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| wr_bit9 | input | 1 | Ninth data bit captured with the byte |
| tc_clr | input | 1 | Clears the transmit-complete flag |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_done | output | 1 | Line idle after the last stop bit |

## Verification
All outputs are registered. `hold_empty` falls one edge after a write and, when the shifter is idle, rises one edge later. Line bits change at baud-tick edges, and `tx_done` rises at the tick edge that ends the stop bit. The bench drives inputs on the falling clock edge and samples on the falling edge after the edge where each result is due. A line monitor reads one bit per tick, decodes each frame against a queue of expected bytes, and records the tick index of every start bit, which is how gapless framing is measured. Flag checks count edges from the write, or wait for the tick edge that ends the stop bit and compare the flag on the falling edge just before and just after it.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_ARMED = 2'd1,
    SH_SEND  = 2'd2
  } sh_state_t;

  function automatic int frame_bits(input int dw, input logic nine);
    return nine ? dw + 3 : dw + 2;
  endfunction
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wx,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              xbit,
  output logic              empty_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full    <= 1'b0;
      data    <= '0;
      xbit    <= 1'b0;
      empty_q <= 1'b1;
    end else if (wr) begin
      full    <= 1'b1;
      data    <= wdata;
      xbit    <= wx;
      empty_q <= 1'b0;
    end else if (take) begin
      full    <= 1'b0;
      empty_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              nine,
  input  logic              pend,
  input  logic [DATA_W-1:0] pend_data,
  input  logic              pend_x,
  output logic              take,
  output logic              fin,
  output logic              txd
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(FW + 1);

  sh_state_t     st;
  logic [FW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;
  logic [FW-1:0] new_frame;
  logic [CW-1:0] new_last;
  logic          at_end;

  // stop bit sits at bit FW-2 (short frame) or FW-1 (long frame)
  assign new_frame = {1'b1, nine ? pend_x : 1'b1, pend_data, 1'b0};
  assign new_last  = CW'(frame_bits(DATA_W, nine) - 1);
  assign at_end    = (st == SH_SEND) && tick && (cnt == last_idx);

  always_comb begin
    take = en && pend && (at_end || (st == SH_IDLE));
    fin  = en && at_end && !pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SH_IDLE;
      sh       <= '1;
      cnt      <= '0;
      last_idx <= '0;
      txd      <= 1'b1;
    end else if (!en) begin
      st  <= SH_IDLE;
      txd <= 1'b1;
    end else if (st == SH_SEND && tick) begin
      if (cnt == last_idx) begin
        if (pend) begin
          sh       <= new_frame;
          last_idx <= new_last;
          cnt      <= '0;
          txd      <= 1'b0;
        end else begin
          st  <= SH_IDLE;
          txd <= 1'b1;
        end
      end else begin
        sh  <= {1'b1, sh[FW-1:1]};
        txd <= sh[1];
        cnt <= cnt + 1'b1;
      end
    end else if (st == SH_ARMED && tick) begin
      st  <= SH_SEND;
      cnt <= '0;
      txd <= sh[0];
    end else if (st == SH_IDLE && pend) begin
      sh       <= new_frame;
      last_idx <= new_last;
      st       <= SH_ARMED;
    end
  end
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk,
  input  logic rst,
  input  logic fin,
  input  logic clr,
  input  logic wr,
  output logic done
);
  always_ff @(posedge clk) begin
    if (rst)            done <= 1'b0;
    else if (clr || wr) done <= 1'b0;
    else if (fin)       done <= 1'b1;
  end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              mode9,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              tc_clr,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_done
);
  logic              full;
  logic [DATA_W-1:0] hdata;
  logic              hx;
  logic              take;
  logic              fin;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr(wr_stb), .wdata(wr_data), .wx(wr_bit9),
    .take(take), .full(full), .data(hdata), .xbit(hx), .empty_q(hold_empty)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .en(tx_en), .tick(baud_tick), .nine(mode9),
    .pend(full), .pend_data(hdata), .pend_x(hx),
    .take(take), .fin(fin), .txd(txd)
  );

  uart_tx_flags u_flags (
    .clk(clk), .rst(rst), .fin(fin), .clr(tc_clr), .wr(wr_stb), .done(tx_done)
  );
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic baud_tick,
  input logic wr_stb,
  input logic tc_clr,
  input logic txd,
  input logic hold_empty,
  input logic tx_done
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> txd); // R10
  AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !baud_tick) |=> $stable(txd)); // R4
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !hold_empty); // R2
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (tc_clr || wr_stb) |=> !tx_done); // R8
  AST_DONE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> (hold_empty && txd)); // R7
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .baud_tick(baud_tick),
  .wr_stb(wr_stb), .tc_clr(tc_clr), .txd(txd),
  .hold_empty(hold_empty), .tx_done(tx_done)
);

// File: tb/uart_tx_dbuf_bench.sv
module uart_tx_dbuf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b1;
  logic baud_tick = 1'b0;
  logic mode9 = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_bit9 = 1'b0;
  logic tc_clr = 1'b0;
  logic txd, hold_empty, tx_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_dbuf u_uart_tx_dbuf (
    .clk(clk), .rst(rst), .tx_en(tx_en), .baud_tick(baud_tick), .mode9(mode9),
    .wr_stb(wr_stb), .wr_data(wr_data), .wr_bit9(wr_bit9), .tc_clr(tc_clr),
    .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // baud tick generator
  int bcnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      bcnt = 0;
      baud_tick <= 1'b0;
    end else if (bcnt == DIV - 1) begin
      bcnt = 0;
      baud_tick <= 1'b1;
    end else begin
      bcnt++;
      baud_tick <= 1'b0;
    end
  end

  // scoreboard: {mode9, bit9, byte}
  logic [9:0] exp_q[$];

  task automatic send(input logic [7:0] d, input logic x, input logic idle);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = d; wr_bit9 = x;
    exp_q.push_back({mode9, x, d});
    @(negedge clk);
    wr_stb = 1'b0;
    chk(hold_empty == 1'b0, "R2 empty low after write", int'(hold_empty), 0);
    if (idle) begin
      @(negedge clk);
      chk(hold_empty == 1'b1, "R2 empty after transfer", int'(hold_empty), 1);
      chk(txd == 1'b1, "R4 no start before tick", int'(txd), 1);
    end
  endtask

  task automatic overwrite(input logic [7:0] d, input logic x);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = d; wr_bit9 = x;
    void'(exp_q.pop_back());
    exp_q.push_back({mode9, x, d});
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // line monitor
  int tk = 0;
  int frames = 0;
  int last_start = 0, prev_start = 0, prev_len = 0, cur_len = 0;
  logic inf = 1'b0;
  int bc = 0;
  logic [10:0] sbits;
  logic [9:0] cur;

  always begin
    @(posedge clk);
    if (!rst && baud_tick) begin
      tk++;
      @(negedge clk);
      if (!inf) begin
        if (txd == 1'b0) begin
          inf = 1'b1; bc = 1; sbits = '0;
          prev_start = last_start; last_start = tk; prev_len = cur_len;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R10 unexpected frame", 1, 0);
            cur = {mode9, 9'h0};
          end else begin
            cur = exp_q.pop_front();
          end
          cur_len = cur[9] ? 11 : 10;
        end
      end else begin
        sbits[bc-1] = txd;
        bc++;
        if (bc == cur_len) begin
          inf = 1'b0;
          if (cur[9]) begin
            chk(sbits[8:0] == cur[8:0], "R5 nine-bit frame data", int'(sbits[8:0]), int'(cur[8:0]));
            chk(sbits[9] == 1'b1, "R5 stop bit", int'(sbits[9]), 1);
          end else begin
            chk(sbits[7:0] == cur[7:0], "R3 eight-bit frame data", int'(sbits[7:0]), int'(cur[7:0]));
            chk(sbits[8] == 1'b1, "R3 stop bit", int'(sbits[8]), 1);
          end
          frames++;
        end
      end
    end
  end

  task automatic wait_frames(input int n);
    while (frames < n) @(negedge clk);
  endtask

  task automatic done_edge_check;
    chk(tx_done == 1'b0, "R7 done not early", int'(tx_done), 0);
    @(posedge clk);
    while (!baud_tick) @(posedge clk);
    @(negedge clk);
    chk(tx_done == 1'b1, "R7 done at stop end", int'(tx_done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    chk(hold_empty == 1'b1, "R1 reset empty", int'(hold_empty), 1);
    chk(tx_done == 1'b0, "R1 reset done", int'(tx_done), 0);

    // single 8-bit frame, done timing, explicit clear
    send(8'hA5, 1'b0, 1'b1);
    wait_frames(1);
    done_edge_check();
    @(negedge clk); tc_clr = 1'b1;
    @(negedge clk); tc_clr = 1'b0;
    chk(tx_done == 1'b0, "R8 clear input", int'(tx_done), 0);

    // 9-bit frames; write clears done
    mode9 = 1'b1;
    send(8'h3C, 1'b1, 1'b1);
    wait_frames(2);
    done_edge_check();
    send(8'h01, 1'b0, 1'b1);
    chk(tx_done == 1'b0, "R8 write clears done", int'(tx_done), 0);
    wait_frames(3);
    done_edge_check();

    // back-to-back 8-bit
    mode9 = 1'b0;
    send(8'h5A, 1'b0, 1'b1);
    send(8'hC3, 1'b0, 1'b0);
    wait_frames(4);
    chk(tx_done == 1'b0, "R7 done low between frames", int'(tx_done), 0);
    wait_frames(5);
    chk(last_start - prev_start == 10, "R6 gapless 8-bit", last_start - prev_start, 10);
    done_edge_check();

    // back-to-back 9-bit
    mode9 = 1'b1;
    send(8'hF0, 1'b1, 1'b1);
    send(8'h0F, 1'b1, 1'b0);
    wait_frames(7);
    chk(last_start - prev_start == 11, "R6 gapless 9-bit", last_start - prev_start, 11);
    done_edge_check();

    // overwrite of a pending byte
    mode9 = 1'b0;
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b0);
    overwrite(8'h99, 1'b0);
    chk(hold_empty == 1'b0, "R9 still pending", int'(hold_empty), 0);
    wait_frames(9);
    chk(exp_q.size() == 0, "R9 only last byte sent", exp_q.size(), 0);
    done_edge_check();

    // disabled transmitter holds the byte
    tx_en = 1'b0;
    send(8'h6E, 1'b0, 1'b0);
    begin
      int bad = 0;
      repeat (60) begin
        @(negedge clk);
        if (txd !== 1'b1) bad++;
      end
      chk(bad == 0, "R10 line idle while off", bad, 0);
    end
    chk(hold_empty == 1'b0, "R10 byte held while off", int'(hold_empty), 0);
    chk(frames == 9, "R10 no frame while off", frames, 9);
    tx_en = 1'b1;
    wait_frames(10);
    done_edge_check();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule